// File: doc/BRIEF.md
# Three-Lane Serial Transmit Serializer

This block turns parallel words from a host into three serial bit streams that leave on a common bit clock and under a common frame-sync qualifier. Each lane has a holding register that the host writes and a shift register that takes over the holding register's word at each word boundary. Word length, bit order and the position of the word inside the register are shared configuration. The bit clock is given as a one-cycle strobe `bit_en` in the system clock domain. A bit moves only on a strobe that arrives while `fsync` is high.

A shared sequencer has two states. ST_IDLE is the state after reset. ST_SHIFT is the state while words are going out. The START transition (ST_IDLE to ST_SHIFT) fires on the first qualified strobe, and that strobe is also the first word boundary. In ST_SHIFT, a qualified strobe on the last bit of a word takes the WRAP transition: ST_SHIFT to ST_SHIFT, a new boundary, and the bit counter goes back to zero. Any other qualified strobe takes ADVANCE and moves the counter by one. A strobe with `fsync` low, or no strobe at all, takes HOLD and leaves everything unchanged.

At every boundary an enabled lane moves its full holding register into its shift register and reports the holding register empty. If the holding register was empty at the boundary, the lane sends its last word again and raises an underrun flag. The next host write clears that flag.

Top module: `tx_serializer3`

## Requirements
- R1: After reset all serial outputs are 0, all empty flags are 1 and all underrun flags are 0.
- R2: With `cfg_lsb_first`=0 the word leaves MSB first. The bit for a boundary strobe appears on `sdo` in the cycle after that strobe and stays until the next qualified strobe. All three lanes shift together.
- R3: With `cfg_lsb_first`=1 the same word bits leave in reverse order, LSB first.
- R4: With `cfg_align`=0 the word MSB is register bit 23 and bits below the word are ignored. With `cfg_align`=1 the word MSB is register bit 15 and bits 23..16 are ignored. Positions below bit 0 are sent as 0.
- R5: `cfg_wl` selects the bits per word: 0=8, 1=12, 2=16, 3=24, 4=32, and codes 5 to 7 act as 24. For 32, with alignment 0, the 24 data bits are followed by 8 zeros when MSB first and preceded by them when LSB first.
- R6: A `bit_en` strobe while `fsync` is low moves no bit. The outputs and the position in the word stay as they are.
- R7: A host write to an enabled lane clears that lane's empty flag in the next cycle. The flag stays clear until the boundary strobe that follows the last bit of the current word.
- R8: When a boundary comes while an enabled lane's holding register is empty, the lane sends its previous word again and sets its underrun flag in the next cycle. A later write clears the flag.
- R9: A lane whose `ch_en` bit is 0 drives `sdo` low, shows empty=1 and underrun=0, and ignores host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-clock strobe |
| fsync | input | 1 | Frame-sync qualifier for shifting |
| cfg_wl | input | 3 | Word-length code |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_align | input | 1 | Word position: 0 MSB at bit 23, 1 MSB at bit 15 |
| ch_en | input | NCH | Per-lane enable |
| wr_en | input | NCH | Per-lane host write strobe |
| wr_data | input | NCH x DW | Per-lane host write data |
| sdo | output | NCH | Serial data outputs |
| empty | output | NCH | Holding register empty, per lane |
| underrun | output | NCH | Underrun flag, per lane |

## Verification
A wrong bit counter or a bad sequencer transition shows up within one word as a shifted or wrongly ordered bit on every enabled lane, so each output bit is compared with the expected value in the cycle after its strobe. A holding or full state that goes wrong shows up at the next boundary as a wrong empty or underrun flag, or as the wrong word being sent. These flags are therefore checked right after the boundary strobe and on the last bit before it. Paused strobes and disabled lanes are checked at the outputs during the stimulus itself.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int FW = 32;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } txs_state_e;

    function automatic logic [5:0] wl_to_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd4:    n = 6'd32;
            default: n = 6'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/txs_frame_ctl.sv
module txs_frame_ctl
    import txs_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          fsync,
    input  logic [5:0]    wl_bits,
    output logic          active,
    output logic          boundary,
    output logic [CW-1:0] cnt
);

    txs_state_e state_q, state_d;
    logic       qual;
    logic       last_bit;

    assign qual     = bit_en && fsync;
    assign last_bit = ({1'b0, cnt} == (wl_bits - 6'd1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: START, WRAP, ADVANCE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (qual) state_d = ST_SHIFT;
            ST_SHIFT: state_d = ST_SHIFT;
        endcase
    end

    // outputs
    always_comb begin
        active   = 1'b0;
        boundary = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                boundary = qual;
            end
            ST_SHIFT: begin
                active   = 1'b1;
                boundary = qual && last_bit;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (boundary) cnt <= '0;
        else if (qual)     cnt <= cnt + 1'b1;
    end

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && fsync) |=> ($stable(cnt) && $stable(active)));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, cnt} < wl_bits));

endmodule

// File: rtl/txs_lane.sv
module txs_lane
    import txs_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          boundary,
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [5:0]    wl_bits,
    input  logic          lsb_first,
    input  logic          align,
    output logic          sdo,
    output logic          empty,
    output logic          underrun
);

    localparam int IW = CW + 1;

    logic [DW-1:0] hold_q;
    logic [DW-1:0] shreg_q;
    logic          full_q;
    logic          urun_q;
    logic [FW-1:0] frame_vec;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shreg_q <= '0;
            full_q  <= 1'b0;
            urun_q  <= 1'b0;
        end else if (!en) begin
            full_q  <= 1'b0;
            urun_q  <= 1'b0;
        end else begin
            if (boundary) begin
                if (full_q) shreg_q <= hold_q;
                else        urun_q  <= 1'b1;
                full_q <= 1'b0;
            end
            if (wr) begin
                hold_q <= wdata;
                full_q <= 1'b1;
                urun_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (align) frame_vec = {shreg_q[DW-9:0], {(FW-DW+8){1'b0}}};
        else       frame_vec = {shreg_q, {(FW-DW){1'b0}}};
    end

    always_comb begin
        if (lsb_first) idx = IW'(FW) - wl_bits + IW'(cnt);
        else           idx = IW'(FW - 1) - IW'(cnt);
    end

    assign sdo      = en && active && frame_vec[idx[CW-1:0]];
    assign empty    = !full_q;
    assign underrun = urun_q;

    // R9
    disabled_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (empty && !underrun));

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && boundary && empty && !wr) |=> underrun);

    // R7
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !empty && !boundary) |=> !empty);

    // R7
    write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr) |=> (!empty && !underrun));

endmodule

// File: rtl/tx_serializer3.sv
module tx_serializer3
    import txs_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic                    fsync,
    input  logic [2:0]              cfg_wl,
    input  logic                    cfg_lsb_first,
    input  logic                    cfg_align,
    input  logic [NCH-1:0]          ch_en,
    input  logic [NCH-1:0]          wr_en,
    input  logic [NCH-1:0][DW-1:0]  wr_data,
    output logic [NCH-1:0]          sdo,
    output logic [NCH-1:0]          empty,
    output logic [NCH-1:0]          underrun
);

    localparam int CW = $clog2(FW);

    logic [5:0]    wl_bits;
    logic          active;
    logic          boundary;
    logic [CW-1:0] cnt;

    assign wl_bits = wl_to_bits(cfg_wl);

    txs_frame_ctl #(.CW(CW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .fsync    (fsync),
        .wl_bits  (wl_bits),
        .active   (active),
        .boundary (boundary),
        .cnt      (cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        txs_lane #(.DW(DW), .CW(CW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[g]),
            .wr        (wr_en[g]),
            .wdata     (wr_data[g]),
            .boundary  (boundary),
            .active    (active),
            .cnt       (cnt),
            .wl_bits   (wl_bits),
            .lsb_first (cfg_lsb_first),
            .align     (cfg_align),
            .sdo       (sdo[g]),
            .empty     (empty[g]),
            .underrun  (underrun[g])
        );
    end

    // R9
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_en[0]) |-> !sdo[0]);

endmodule

// File: tb/tx_serializer3_test.sv
module tx_serializer3_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int DW  = 24;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   bit_en;
    logic                   fsync;
    logic [2:0]             cfg_wl;
    logic                   cfg_lsb_first;
    logic                   cfg_align;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         wr_en;
    logic [NCH-1:0][DW-1:0] wr_data;
    logic [NCH-1:0]         sdo;
    logic [NCH-1:0]         empty;
    logic [NCH-1:0]         underrun;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] cur [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_serializer3 #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
        .cfg_wl(cfg_wl), .cfg_lsb_first(cfg_lsb_first), .cfg_align(cfg_align),
        .ch_en(ch_en), .wr_en(wr_en), .wr_data(wr_data),
        .sdo(sdo), .empty(empty), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int wl_n(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd4: return 32;
            default: return 24;
        endcase
    endfunction

    // bit k in send order, built from the requirement text
    function automatic logic exp_bit(input logic [DW-1:0] d, input int k);
        int w, top, j, pos;
        w   = wl_n(cfg_wl);
        top = cfg_align ? 15 : 23;
        j   = cfg_lsb_first ? (w - 1 - k) : k;
        pos = top - j;
        return (pos >= 0) ? d[pos] : 1'b0;
    endfunction

    task automatic do_reset(input logic [2:0] wl, input logic lsb, input logic al);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; wr_en = '0; wr_data = '0;
        ch_en = '1; cfg_wl = wl; cfg_lsb_first = lsb; cfg_align = al;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick(input logic fs);
        @(negedge clk);
        bit_en = 1'b1; fsync = fs;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic write(input int ch, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = '0; wr_en[ch] = 1'b1; wr_data[ch] = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
        if (ch_en[ch]) cur[ch] = d;
    endtask

    task automatic run_bits(input string req, input int first, input int count);
        for (int k = first; k < first + count; k++) begin
            tick(1'b1);
            for (int c = 0; c < NCH; c++)
                chk(req, 32'(sdo[c]), 32'(ch_en[c] ? exp_bit(cur[c], k) : 1'b0));
        end
    endtask

    task automatic t_reset;
        do_reset(3'd3, 1'b0, 1'b0);
        chk("R1 sdo", 32'(sdo), 32'h0);
        chk("R1 empty", 32'(empty), 32'h7);
        chk("R1 underrun", 32'(underrun), 32'h0);
    endtask

    task automatic t_msb24;
        do_reset(3'd3, 1'b0, 1'b0);
        write(0, 24'hA5C3_0F); write(1, 24'h123456); write(2, 24'hFEDCBA);
        run_bits("R2 msb24", 0, 24);
        write(0, 24'h0F0F0F); write(1, 24'h800001); write(2, 24'h5A5A5A);
        run_bits("R2 msb24 word2", 0, 24);
    endtask

    task automatic t_order_align;
        do_reset(3'd2, 1'b1, 1'b1);
        write(0, 24'hFF_8001); write(1, 24'h00_1234); write(2, 24'hAB_C00F);
        run_bits("R3 R4 lsb16 align1", 0, 16);
        do_reset(3'd3, 1'b0, 1'b1);
        write(0, 24'hFF_8001); write(1, 24'h77_F0F0); write(2, 24'h01_0203);
        run_bits("R4 align1 wl24 zero tail", 0, 24);
    endtask

    task automatic t_lengths;
        for (int code = 0; code < 6; code++) begin
            for (int o = 0; o < 2; o++) begin
                do_reset(3'(code), 1'(o), 1'b0);
                write(0, 24'hC3_81E7); write(1, 24'h9_6A5F0); write(2, 24'h00_FF11);
                run_bits("R5 word length", 0, wl_n(3'(code)));
                write(0, 24'h3C_7E18); write(1, 24'hFFFFFF); write(2, 24'h800000);
                run_bits("R5 next word boundary", 0, wl_n(3'(code)));
            end
        end
    endtask

    task automatic t_pause;
        logic [NCH-1:0] held;
        do_reset(3'd3, 1'b0, 1'b0);
        write(0, 24'hB7_1D29); write(1, 24'h4E_E401); write(2, 24'hD0_0D0D);
        run_bits("R6 before pause", 0, 5);
        held = sdo;
        for (int p = 0; p < 3; p++) begin
            tick(1'b0);
            chk("R6 paused sdo", 32'(sdo), 32'(held));
        end
        run_bits("R6 after pause", 5, 19);
    endtask

    task automatic t_empty;
        do_reset(3'd0, 1'b0, 1'b0);
        write(0, 24'hAA0000); write(1, 24'h550000); write(2, 24'hF00000);
        chk("R7 full after write", 32'(empty), 32'h0);
        run_bits("R7 word A", 0, 1);
        chk("R7 empty at boundary", 32'(empty), 32'h7);
        write(0, 24'h3C0000); write(1, 24'hC30000); write(2, 24'h0F0000);
        chk("R7 refilled", 32'(empty), 32'h0);
        for (int c = 0; c < NCH; c++) cur[c] = (c == 0) ? 24'hAA0000 : (c == 1) ? 24'h550000 : 24'hF00000;
        run_bits("R7 word A rest", 1, 7);
        chk("R7 still full on last bit", 32'(empty), 32'h0);
        cur[0] = 24'h3C0000; cur[1] = 24'hC30000; cur[2] = 24'h0F0000;
        run_bits("R7 word B", 0, 1);
        chk("R7 empty after word", 32'(empty), 32'h7);
    endtask

    task automatic t_underrun;
        do_reset(3'd0, 1'b0, 1'b0);
        write(0, 24'hD20000);
        cur[1] = '0; cur[2] = '0;
        run_bits("R8 first word", 0, 1);
        chk("R8 unwritten lanes flag", 32'(underrun), 32'h6);
        run_bits("R8 first word rest", 1, 7);
        run_bits("R8 repeat word", 0, 1);
        chk("R8 lane0 flag", 32'(underrun), 32'h7);
        run_bits("R8 repeat rest", 1, 7);
        write(0, 24'h2D0000);
        chk("R8 cleared by write", 32'(underrun), 32'h6);
        run_bits("R8 new word", 0, 8);
    endtask

    task automatic t_disable;
        do_reset(3'd1, 1'b0, 1'b0);
        ch_en = 3'b101;
        @(negedge clk);
        cur[1] = '0;
        write(0, 24'hFFF000); write(1, 24'hFFFFFF); write(2, 24'hABC000);
        chk("R9 disabled empty", 32'(empty), 32'h2);
        run_bits("R9 disabled lane low", 0, 12);
        chk("R9 disabled no underrun", 32'(underrun[1]), 32'h0);
        chk("R9 disabled sdo", 32'(sdo[1]), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; wr_en = '0; wr_data = '0;
        ch_en = '1; cfg_wl = 3'd3; cfg_lsb_first = 1'b0; cfg_align = 1'b0;
        for (int c = 0; c < NCH; c++) cur[c] = '0;
        t_reset;
        t_msb24;
        t_order_align;
        t_lengths;
        t_pause;
        t_empty;
        t_underrun;
        t_disable;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule